// File: doc/BRIEF.md
# Two-Decade BCD Rate Multiplier

This block thins a stream of divided-output strobes. It emits exactly T·10+U requests for every hundred strobes, where T and U are the tens and units digits of a two-digit BCD rate. A fractional-N divider uses it this way: each request tells the swallow synchronizer to shorten one division cycle by one input pulse. Over a hundred divided cycles, T·10+U of them are shortened. The average divide ratio then takes a fractional part equal to the rate divided by one hundred.

Inside, two decade counters are cascaded. The units decade counts strobes, and the tens decade counts wraps of the units decade. A selection stage picks the strobes that raise a request. Tens-digit requests are spread across units positions 0 to 8. Units-digit requests use units position 9 only, spread across the tens positions. The two kinds of request can never fall on the same strobe. A stretcher holds each request high for a fixed number of clocks, long enough for the slower synchronizer to capture it.

There is no data stream here, so every pin is a plain control or status pin and no back-pressure applies. Strobes spaced closer than STRETCH+1 clocks can merge into a single request.

Top module: `bcd_rate_mult`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears both decade counters and the stretcher. req_o is low during reset and after reset. The first strobe after reset is handled at units position 0 and tens position 0.
- R2: The counters advance, and requests can start, only on a clock where step_i is high. With no strobes, req_o falls after its stretch and stays low.
- R3: While enable_i is low, no strobe raises a request, but the decade counters still advance on every strobe.
- R4: A strobe that selects a request drives req_o high from the next clock for exactly STRETCH clocks (default 8).
- R5: With enable_i high and a constant rate, any hundred consecutive strobes raise exactly T·10+U requests. Rate 00 gives none and rate 99 gives 99.
- R6: A digit code above 9 on rate_tens_i or rate_units_i is treated as 9.
- R7: A tens-digit request fires at units position c (0..8) when floor((c+1)·T/9) > floor(c·T/9). A units-digit request fires at units position 9 and tens position k when floor((k+1)·U/10) > floor(k·U/10). So each aligned group of ten strobes carries T or T+1 requests, and with rate 10 the first request after reset comes from the ninth strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Divided-output strobe, one clock wide |
| enable_i | input | 1 | High lets selected strobes raise requests |
| rate_tens_i | input | 4 | Tens BCD digit of the rate |
| rate_units_i | input | 4 | Units BCD digit of the rate |
| req_o | output | 1 | Stretched request to the swallow synchronizer |

## Verification
The bench sweeps rates that include 00, 99 and out-of-range digit codes. A design that let the units slot overlap a tens slot would lose one request, so the count would fall short of the rate. A design that skipped clamping would let codes above 9 overflow or wrap the pattern. Aligned groups of ten strobes are counted one by one, so placement that bunches requests shows up as a group outside T..T+1. The bench also times the first request after reset, and after strobes taken while disabled, which exposes decades that fail to clear on reset or freeze while disabled. It measures the stretch width exactly, which exposes an off-by-one in the stretcher.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam int unsigned DIG_W   = 4;
  localparam int unsigned DIG_TOP = 9;
  localparam int unsigned NDEC    = 2;
  localparam int unsigned TENS_SLOTS  = DIG_TOP;
  localparam int unsigned UNITS_SLOTS = DIG_TOP + 1;

  typedef logic [DIG_W-1:0] bcd_t;

  function automatic bcd_t clamp_digit(bcd_t d);
    return (d > bcd_t'(DIG_TOP)) ? bcd_t'(DIG_TOP) : d;
  endfunction

  // Evenly spread `d` hits over `slots` positions, position `c`.
  function automatic logic spread_hit(int slots, bcd_t d, bcd_t c);
    int cc;
    int dd;
    cc = int'(c);
    dd = int'(d);
    return (((cc + 1) * dd) / slots) != ((cc * dd) / slots);
  endfunction
endpackage

// File: rtl/rm_decade.sv
module rm_decade
  import rm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output bcd_t cnt_o,
  output logic last_o
);
  bcd_t cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (adv_i) begin
      if (cnt_q == bcd_t'(DIG_TOP)) cnt_q <= '0;
      else                          cnt_q <= cnt_q + bcd_t'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == bcd_t'(DIG_TOP));

  // R1: count stays a legal decade value
  p_digit_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= bcd_t'(DIG_TOP));

  // R5: decade wraps to zero after its last position
  p_decade_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && last_o) |=> (cnt_o == '0));

  // R2: no strobe, no movement
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(cnt_o));
endmodule

// File: rtl/rm_gate.sv
module rm_gate
  import rm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic en_i,
  input  bcd_t units_pos_i,
  input  bcd_t tens_pos_i,
  input  bcd_t digit_t_i,
  input  bcd_t digit_u_i,
  output logic fire_o
);
  bcd_t dt;
  bcd_t du;
  logic units_slot;
  logic tens_hit;
  logic units_hit;

  always_comb begin
    dt         = clamp_digit(digit_t_i);
    du         = clamp_digit(digit_u_i);
    units_slot = (units_pos_i == bcd_t'(DIG_TOP));
    tens_hit   = !units_slot && spread_hit(int'(TENS_SLOTS), dt, units_pos_i);
    units_hit  = units_slot && spread_hit(int'(UNITS_SLOTS), du, tens_pos_i);
    fire_o     = step_i && en_i && (tens_hit || units_hit);
  end

  // R3: disabled means silent
  p_quiet_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !fire_o);

  // R2: requests only start on strobes
  p_fire_on_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |-> !fire_o);

  // R7: units slot reserved for the units digit
  p_units_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (units_slot && digit_u_i == '0) |-> !fire_o);

  // R5: rate 00 never fires
  p_zero_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_t_i == '0 && digit_u_i == '0) |-> !fire_o);
endmodule

// File: rtl/rm_stretch.sv
module rm_stretch #(
  parameter int unsigned LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic req_o
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LEN_C = CW'(LEN);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (fire_i) begin
      left_q <= LEN_C;
    end else if (left_q != '0) begin
      left_q <= left_q - CW'(1);
    end
  end

  assign req_o = (left_q != '0);

  // R4: a request is visible on the following clock
  p_fire_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> req_o);

  // R4: hold time never exceeds the configured length
  p_len_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= LEN_C);

  // R4: a fresh request starts at full length
  p_full_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> (left_q == LEN_C));
endmodule

// File: rtl/bcd_rate_mult.sv
module bcd_rate_mult
  import rm_pkg::*;
#(
  parameter int unsigned STRETCH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_i,
  input  logic       enable_i,
  input  logic [3:0] rate_tens_i,
  input  logic [3:0] rate_units_i,
  output logic       req_o
);
  logic [NDEC-1:0] adv;
  logic [NDEC-1:0] last;
  bcd_t            pos [NDEC];
  logic            fire;

  for (genvar i = 0; i < NDEC; i++) begin : g_dec
    if (i == 0) begin : g_first
      assign adv[i] = step_i;
    end else begin : g_chain
      assign adv[i] = adv[i-1] && last[i-1];
    end
    rm_decade u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (adv[i]),
      .cnt_o  (pos[i]),
      .last_o (last[i])
    );
  end

  rm_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_i),
    .en_i        (enable_i),
    .units_pos_i (pos[0]),
    .tens_pos_i  (pos[1]),
    .digit_t_i   (rate_tens_i),
    .digit_u_i   (rate_units_i),
    .fire_o      (fire)
  );

  rm_stretch #(.LEN(STRETCH)) u_stretch (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (fire),
    .req_o  (req_o)
  );

  // R2: tens decade moves only when the units decade wraps on a strobe
  p_tens_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_i && last[0]) |=> $stable(pos[1]));

  // R3: counters keep advancing while disabled
  p_adv_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !enable_i && !last[0]) |=> (pos[0] != '0));
endmodule

// File: tb/test_bcd_rate_mult.sv
`timescale 1ns/1ps
module test_bcd_rate_mult;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step = 1'b0;
  logic       en = 1'b0;
  logic [3:0] rt = '0;
  logic [3:0] ru = '0;
  logic       req;

  int errors = 0;
  int checks = 0;
  int rises = 0;
  logic req_prev = 1'b0;

  always #2 clk = ~clk;

  bcd_rate_mult #(.STRETCH(8)) i_bcd_rate_mult (
    .clk(clk), .rst_n(rst_n), .step_i(step), .enable_i(en),
    .rate_tens_i(rt), .rate_units_i(ru), .req_o(req)
  );

  always @(negedge clk) begin
    if (req && !req_prev) rises++;
    req_prev = req;
  end

  // {tens, units, expected per 100}
  localparam logic [15:0] VEC [9] = '{
    16'h3220, 16'h0000, 16'h9963, 16'h5032, 16'h0707,
    16'h905A, 16'h150F, 16'hF55F, 16'h9F63
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic one_step();
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    repeat (11) @(negedge clk);
  endtask

  // index (0-based) of the first strobe that raised a request, -1 if none in max
  task automatic first_hit(input int max, output int idx);
    int base;
    base = rises;
    idx = -1;
    for (int s = 0; s < max; s++) begin
      one_step();
      if (idx < 0 && rises != base) idx = s;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int idx;
    int base;
    int width;

    // R1: request low while held in reset
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(req == 1'b0, "R1 req in reset", int'(req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req == 1'b0, "R1 req after reset", int'(req), 0);

    // Vector table: R5/R6 totals, R7 per-group spread
    for (int v = 0; v < 9; v++) begin
      int t_eff;
      int total_base;
      rt = VEC[v][15:12];
      ru = VEC[v][11:8];
      t_eff = (int'(rt) > 9) ? 9 : int'(rt);
      en = 1'b1;
      do_reset();
      total_base = rises;
      for (int g = 0; g < 10; g++) begin
        int gb;
        gb = rises;
        for (int s = 0; s < 10; s++) one_step();
        check((rises - gb) >= t_eff && (rises - gb) <= t_eff + 1,
              $sformatf("R7 group %0d rate %h%h", g, rt, ru), rises - gb, t_eff);
      end
      check((rises - total_base) == int'(VEC[v][7:0]),
            $sformatf("R5 R6 total rate %h%h", rt, ru),
            rises - total_base, int'(VEC[v][7:0]));
    end

    // R1/R7: rate 10, first request from ninth strobe; again after mid-run reset
    rt = 4'd1; ru = 4'd0; en = 1'b1;
    do_reset();
    first_hit(12, idx);
    check(idx == 8, "R7 first hit rate 10", idx, 8);
    do_reset();
    for (int s = 0; s < 3; s++) one_step();
    do_reset();
    first_hit(12, idx);
    check(idx == 8, "R1 restart after reset", idx, 8);

    // R4: stretch width
    rt = 4'd9; ru = 4'd9;
    do_reset();
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    width = 0;
    while (req && width < 50) begin
      width++;
      @(negedge clk);
    end
    check(width == 8, "R4 stretch width", width, 8);

    // R2: no strobes, no requests
    base = rises;
    repeat (100) @(negedge clk);
    check(rises == base, "R2 idle rises", rises - base, 0);
    check(req == 1'b0, "R2 idle req", int'(req), 0);

    // R3: disabled, rate 99, 100 strobes
    en = 1'b0;
    do_reset();
    base = rises;
    for (int s = 0; s < 100; s++) one_step();
    check(rises == base, "R3 disabled rises", rises - base, 0);
    check(req == 1'b0, "R3 disabled req", int'(req), 0);

    // R3: counters advance while disabled (5 strobes, then hit at position 8)
    rt = 4'd1; ru = 4'd0; en = 1'b0;
    do_reset();
    for (int s = 0; s < 5; s++) one_step();
    en = 1'b1;
    first_hit(12, idx);
    check(idx == 3, "R3 advance while disabled", idx, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule